// File: doc/BRIEF.md
# Dual-Channel Banked Register Decoder

This block sits between a host bus and the two channel cores of a dual UART. The host presents a 3-bit register address, an active-low chip select, a channel select and active-low read and write strobes. The block turns each access into a register read or a register write for one channel, or for both channels at once. Each address carries several registers. Which one is reached depends on the channel's line control value and on a feature control bit. There are three banks: a normal bank, a divisor bank (line control bit 7 set) and an enhanced bank (line control equal to 0xBF).

The block stores the state that steers bank selection: line control, the two divisor bytes, enhanced feature, feature control, alternate function and scratch pad. It does this for each channel. Registers kept inside the cores are reached in two ways. Writes go out on a registered one-cycle strobe with a register code and the write data. Reads take their values from the core inputs. A read of the receive holding register or of the modem status register also sends a one-cycle read pulse to that core, so the core can pop its FIFO or clear its status.

All inputs are synchronous to `clk`. A write commits on the clock where a rising write strobe is seen while chip select is low. A read loads the read data register on every clock where read strobe and chip select are both low.

Top module: `uart_regdec`

## Requirements
- R1: With `cs_n` low, `ch_sel`=1 selects channel A (index 0) and `ch_sel`=0 selects channel B (index 1). With `cs_n` high, no write reaches any channel.
- R2: When bit 0 of the selected channel's alternate function register is 1, one write reaches both channels. Each channel decodes the write under its own bank. When the bit is 0, only the selected channel is written.
- R3: With line control bit 7 = 1 and line control not 0xBF, addresses 0, 1 and 2 reach the low divisor byte, the high divisor byte and the alternate function register. These are written and read back without any core strobe.
- R4: With line control = 0xBF, the enhanced bank applies:
  - address 0 reads `core_fc` and writes code 6 (trigger);
  - address 1 is feature control;
  - address 2 is enhanced feature;
  - addresses 4, 5, 6 and 7 read `core_xchar` entries 0 to 3 and write codes 7, 8, 9 and 10.
- R5: In the divisor bank, when both divisor bytes are zero, address 0 reads `REV_CODE` (default 0x01) and address 1 reads `DEV_ID` (default 0x0A).
- R6: At address 7 outside the enhanced bank, feature control bit 6 decides the target:
  - bit 6 = 0: reads return the scratch pad, and writes load the scratch pad;
  - bit 6 = 1: reads return `core_flvl`, and writes issue code 5.
- R7: When enhanced feature bit 4 = 0, the extension bits are forced to zero in both directions:
  - written data for interrupt enable bits 7:4, FIFO control bits 5:4 and modem control bits 7:5;
  - read data for interrupt enable bits 7:4, interrupt status bits 5:4 and modem control bits 7:5.

  When bit 4 = 1, all bits pass.
- R8: After reset the following hold:
  - line control is 0x00 and the scratch pad is 0xFF;
  - the divisor bytes, alternate function, feature control and enhanced feature registers are 0x00;
  - `rdata` is 0x00 and no strobe or pulse is active.
- R9: A write commits once, on the clock where `wr_n` rises with `cs_n` low. `core_wr_stb` is high for exactly the next cycle, with `core_wr_sel` and `core_wr_data`. The codes are 0 none, 1 transmit holding, 2 interrupt enable, 3 FIFO control, 4 modem control, 5 extended modem status, 6 trigger, 7 to 10 flow characters 1 to 4.
- R10: A falling `rd_n` with `cs_n` low produces a one-cycle pulse to the selected channel:
  - on `core_rd_rhr` at address 0 when line control bit 7 = 0;
  - on `core_rd_msr` at address 6 when line control is not 0xBF.

  `rdata` is valid one cycle after `rd_n` falls.
- R11: In the normal bank (line control bit 7 = 0):
  - reads at addresses 0 to 6 return receive holding, interrupt enable, interrupt status, line control, modem control, line status and modem status;
  - writes at addresses 0, 1, 2 and 4 issue codes 1, 2, 3 and 4, and address 3 loads line control;
  - writes at addresses 5 and 6 are ignored.

  Address 3 is line control in every bank, and addresses 4 to 6 in the divisor bank behave as in the normal bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ch_sel | input | 1 | Channel select, 1 = A, 0 = B |
| addr | input | 3 | Register address |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, commits on rise |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| core_rhr | input | 2x8 | Receive holding value per channel |
| core_ier | input | 2x8 | Interrupt enable value per channel |
| core_isr | input | 2x8 | Interrupt status value per channel |
| core_mcr | input | 2x8 | Modem control value per channel |
| core_lsr | input | 2x8 | Line status value per channel |
| core_msr | input | 2x8 | Modem status value per channel |
| core_flvl | input | 2x8 | FIFO level value per channel |
| core_fc | input | 2x8 | FIFO count value per channel |
| core_xchar | input | 2x4x8 | Flow characters 1 to 4 per channel |
| core_wr_stb | output | 2 | One-cycle write strobe per channel |
| core_wr_sel | output | 2x4 | Write register code per channel |
| core_wr_data | output | 2x8 | Write data per channel, extension bits gated |
| core_rd_rhr | output | 2 | Receive holding read pulse per channel |
| core_rd_msr | output | 2 | Modem status read pulse per channel |

## Verification
Directed sequences walk each bank in turn: normal, divisor with zero and non-zero divisor, and enhanced. They show that the same address reaches a different register once line control changes. Alternate-function writes switch between single-channel and two-channel writes. When the channels hold different line control values, the two strobes must carry different codes. Writes with chip select high and writes where the strobe has not yet risen separate real commits from ignored cycles. Random accesses with random line control values, including 0x80 and 0xBF, are then compared against a bench model of the bank state. The core values change before every read, which separates the core-fed registers from the locally held ones.

// File: rtl/uart_regdec_pkg.sv
package uart_regdec_pkg;
  localparam int NCH = 2;

  typedef enum logic [3:0] {
    WS_NONE  = 4'd0,
    WS_THR   = 4'd1,
    WS_IER   = 4'd2,
    WS_FCR   = 4'd3,
    WS_MCR   = 4'd4,
    WS_EMSR  = 4'd5,
    WS_TRG   = 4'd6,
    WS_XON1  = 4'd7,
    WS_XON2  = 4'd8,
    WS_XOFF1 = 4'd9,
    WS_XOFF2 = 4'd10
  } wsel_e;

  typedef enum logic [1:0] {
    BK_NORM,
    BK_DIV,
    BK_ENH
  } bank_e;
endpackage

// File: rtl/uart_regdec_front.sv
module uart_regdec_front (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic ch_sel,
  input  logic rd_n,
  input  logic wr_n,
  output logic wr_fire,
  output logic rd_fire,
  output logic rd_act,
  output logic sel_idx
);
  logic wr_n_q, rd_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_n_q <= 1'b1;
      rd_n_q <= 1'b1;
    end else begin
      wr_n_q <= wr_n;
      rd_n_q <= rd_n;
    end
  end

  // channel A sits at index 0
  assign sel_idx = ~ch_sel;
  assign wr_fire = !cs_n && !wr_n_q && wr_n;
  assign rd_fire = !cs_n && rd_n_q && !rd_n;
  assign rd_act  = !cs_n && !rd_n;
endmodule

// File: rtl/uart_regdec_chan.sv
module uart_regdec_chan
  import uart_regdec_pkg::*;
#(
  parameter int             DW       = 8,
  parameter int             AW       = 3,
  parameter logic [DW-1:0]  ENH_KEY  = 8'hBF,
  parameter logic [DW-1:0]  REV_CODE = 8'h01,
  parameter logic [DW-1:0]  DEV_ID   = 8'h0A,
  parameter logic [DW-1:0]  SPR_RST  = 8'hFF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_fire,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  input  logic [DW-1:0]      in_rhr,
  input  logic [DW-1:0]      in_ier,
  input  logic [DW-1:0]      in_isr,
  input  logic [DW-1:0]      in_mcr,
  input  logic [DW-1:0]      in_lsr,
  input  logic [DW-1:0]      in_msr,
  input  logic [DW-1:0]      in_flvl,
  input  logic [DW-1:0]      in_fc,
  input  logic [3:0][DW-1:0] in_xchar,
  output logic [DW-1:0]      rd_val,
  output logic               wr_stb,
  output logic [3:0]         wr_sel,
  output logic [DW-1:0]      wr_data,
  output logic               rd_rhr,
  output logic               rd_msr,
  output logic               cw_bit,
  output logic               ext_en
);
  localparam int            EXT_BIT  = 4;
  localparam int            LVL_BIT  = 6;
  localparam logic [DW-1:0] IER_KEEP = DW'(8'h0F);
  localparam logic [DW-1:0] ISR_KEEP = DW'(8'hCF);
  localparam logic [DW-1:0] FCR_KEEP = DW'(8'hCF);
  localparam logic [DW-1:0] MCR_KEEP = DW'(8'h1F);
  localparam logic [DW-1:0] ALL_ONES = '1;

  logic [DW-1:0] lcr_q, dll_q, dlm_q, afr_q, fctr_q, efr_q, spr_q;
  bank_e         bank;
  logic          div_zero;
  wsel_e         nsel;
  logic [DW-1:0] ndata;
  logic          ld_lcr, ld_dll, ld_dlm, ld_afr, ld_fctr, ld_efr, ld_spr;
  int            ai;

  assign ai       = int'(addr);
  assign ext_en   = efr_q[EXT_BIT];
  assign cw_bit   = afr_q[0];
  assign div_zero = (dll_q == '0) && (dlm_q == '0);

  always_comb begin
    if (lcr_q == ENH_KEY)    bank = BK_ENH;
    else if (lcr_q[DW-1])    bank = BK_DIV;
    else                     bank = BK_NORM;
  end

  // read selection
  always_comb begin
    rd_val = '0;
    case (ai)
      0: rd_val = (bank == BK_ENH) ? in_fc :
                  (bank == BK_DIV) ? (div_zero ? REV_CODE : dll_q) : in_rhr;
      1: rd_val = (bank == BK_ENH) ? fctr_q :
                  (bank == BK_DIV) ? (div_zero ? DEV_ID : dlm_q) :
                  (in_ier & (ext_en ? ALL_ONES : IER_KEEP));
      2: rd_val = (bank == BK_ENH) ? efr_q :
                  (bank == BK_DIV) ? afr_q :
                  (in_isr & (ext_en ? ALL_ONES : ISR_KEEP));
      3: rd_val = lcr_q;
      4: rd_val = (bank == BK_ENH) ? in_xchar[0] :
                  (in_mcr & (ext_en ? ALL_ONES : MCR_KEEP));
      5: rd_val = (bank == BK_ENH) ? in_xchar[1] : in_lsr;
      6: rd_val = (bank == BK_ENH) ? in_xchar[2] : in_msr;
      7: rd_val = (bank == BK_ENH) ? in_xchar[3] :
                  (fctr_q[LVL_BIT] ? in_flvl : spr_q);
      default: rd_val = '0;
    endcase
  end

  // write selection
  always_comb begin
    nsel    = WS_NONE;
    ndata   = wdata;
    ld_lcr  = 1'b0;
    ld_dll  = 1'b0;
    ld_dlm  = 1'b0;
    ld_afr  = 1'b0;
    ld_fctr = 1'b0;
    ld_efr  = 1'b0;
    ld_spr  = 1'b0;
    case (ai)
      0: begin
        if (bank == BK_ENH)      nsel = WS_TRG;
        else if (bank == BK_DIV) ld_dll = 1'b1;
        else                     nsel = WS_THR;
      end
      1: begin
        if (bank == BK_ENH)      ld_fctr = 1'b1;
        else if (bank == BK_DIV) ld_dlm = 1'b1;
        else begin
          nsel  = WS_IER;
          ndata = wdata & (ext_en ? ALL_ONES : IER_KEEP);
        end
      end
      2: begin
        if (bank == BK_ENH)      ld_efr = 1'b1;
        else if (bank == BK_DIV) ld_afr = 1'b1;
        else begin
          nsel  = WS_FCR;
          ndata = wdata & (ext_en ? ALL_ONES : FCR_KEEP);
        end
      end
      3: ld_lcr = 1'b1;
      4: begin
        if (bank == BK_ENH) nsel = WS_XON1;
        else begin
          nsel  = WS_MCR;
          ndata = wdata & (ext_en ? ALL_ONES : MCR_KEEP);
        end
      end
      5: if (bank == BK_ENH) nsel = WS_XON2;
      6: if (bank == BK_ENH) nsel = WS_XOFF1;
      7: begin
        if (bank == BK_ENH)        nsel = WS_XOFF2;
        else if (fctr_q[LVL_BIT])  nsel = WS_EMSR;
        else                       ld_spr = 1'b1;
      end
      default: nsel = WS_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lcr_q   <= '0;
      dll_q   <= '0;
      dlm_q   <= '0;
      afr_q   <= '0;
      fctr_q  <= '0;
      efr_q   <= '0;
      spr_q   <= SPR_RST;
      wr_stb  <= 1'b0;
      wr_sel  <= '0;
      wr_data <= '0;
      rd_rhr  <= 1'b0;
      rd_msr  <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      rd_rhr <= rd_fire && (ai == 0) && (bank == BK_NORM);
      rd_msr <= rd_fire && (ai == 6) && (bank != BK_ENH);
      if (wr_en) begin
        if (ld_lcr)  lcr_q  <= wdata;
        if (ld_dll)  dll_q  <= wdata;
        if (ld_dlm)  dlm_q  <= wdata;
        if (ld_afr)  afr_q  <= wdata;
        if (ld_fctr) fctr_q <= wdata;
        if (ld_efr)  efr_q  <= wdata;
        if (ld_spr)  spr_q  <= wdata;
        if (nsel != WS_NONE) begin
          wr_stb  <= 1'b1;
          wr_sel  <= nsel;
          wr_data <= ndata;
        end
      end
    end
  end
endmodule

// File: rtl/uart_regdec.sv
module uart_regdec
  import uart_regdec_pkg::*;
#(
  parameter int            DW       = 8,
  parameter int            AW       = 3,
  parameter logic [DW-1:0] ENH_KEY  = 8'hBF,
  parameter logic [DW-1:0] REV_CODE = 8'h01,
  parameter logic [DW-1:0] DEV_ID   = 8'h0A,
  parameter logic [DW-1:0] SPR_RST  = 8'hFF
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cs_n,
  input  logic                      ch_sel,
  input  logic [AW-1:0]             addr,
  input  logic                      rd_n,
  input  logic                      wr_n,
  input  logic [DW-1:0]             wdata,
  output logic [DW-1:0]             rdata,
  input  logic [NCH-1:0][DW-1:0]    core_rhr,
  input  logic [NCH-1:0][DW-1:0]    core_ier,
  input  logic [NCH-1:0][DW-1:0]    core_isr,
  input  logic [NCH-1:0][DW-1:0]    core_mcr,
  input  logic [NCH-1:0][DW-1:0]    core_lsr,
  input  logic [NCH-1:0][DW-1:0]    core_msr,
  input  logic [NCH-1:0][DW-1:0]    core_flvl,
  input  logic [NCH-1:0][DW-1:0]    core_fc,
  input  logic [NCH-1:0][3:0][DW-1:0] core_xchar,
  output logic [NCH-1:0]            core_wr_stb,
  output logic [NCH-1:0][3:0]       core_wr_sel,
  output logic [NCH-1:0][DW-1:0]    core_wr_data,
  output logic [NCH-1:0]            core_rd_rhr,
  output logic [NCH-1:0]            core_rd_msr
);
  logic                   wr_fire, rd_fire, rd_act, sel_idx;
  logic [NCH-1:0]         cw_bits, ext_bits, wr_en;
  logic [NCH-1:0][DW-1:0] rd_vals;

  uart_regdec_front u_front (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .ch_sel  (ch_sel),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .wr_fire (wr_fire),
    .rd_fire (rd_fire),
    .rd_act  (rd_act),
    .sel_idx (sel_idx)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic own;
    assign own      = (int'(sel_idx) == g);
    assign wr_en[g] = wr_fire && (own || cw_bits[sel_idx]);

    uart_regdec_chan #(
      .DW       (DW),
      .AW       (AW),
      .ENH_KEY  (ENH_KEY),
      .REV_CODE (REV_CODE),
      .DEV_ID   (DEV_ID),
      .SPR_RST  (SPR_RST)
    ) u_chan (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en[g]),
      .rd_fire  (rd_fire && own),
      .addr     (addr),
      .wdata    (wdata),
      .in_rhr   (core_rhr[g]),
      .in_ier   (core_ier[g]),
      .in_isr   (core_isr[g]),
      .in_mcr   (core_mcr[g]),
      .in_lsr   (core_lsr[g]),
      .in_msr   (core_msr[g]),
      .in_flvl  (core_flvl[g]),
      .in_fc    (core_fc[g]),
      .in_xchar (core_xchar[g]),
      .rd_val   (rd_vals[g]),
      .wr_stb   (core_wr_stb[g]),
      .wr_sel   (core_wr_sel[g]),
      .wr_data  (core_wr_data[g]),
      .rd_rhr   (core_rd_rhr[g]),
      .rd_msr   (core_rd_msr[g]),
      .cw_bit   (cw_bits[g]),
      .ext_en   (ext_bits[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_act) rdata <= rd_vals[sel_idx];
  end
endmodule

// File: rtl/uart_regdec_chk.sv
module uart_regdec_chk #(
  parameter int NCH = 2,
  parameter int DW  = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cs_n,
  input logic [NCH-1:0]         core_wr_stb,
  input logic [NCH-1:0][3:0]    core_wr_sel,
  input logic [NCH-1:0][DW-1:0] core_wr_data,
  input logic [NCH-1:0]         core_rd_rhr,
  input logic [NCH-1:0]         core_rd_msr,
  input logic [NCH-1:0]         cw_bits,
  input logic [NCH-1:0]         ext_bits
);
  // R9
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    (|core_wr_stb) |=> !(|core_wr_stb));

  // R1
  cs_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n) |-> (core_wr_stb == '0));

  // R2
  both_need_cw_chk: assert property (@(posedge clk) disable iff (rst)
    (&core_wr_stb) |-> $past(|cw_bits));

  // R10
  rd_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    (|(core_rd_rhr | core_rd_msr)) |=> !(|(core_rd_rhr | core_rd_msr)));

  // R10
  rd_pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    ((core_rd_rhr & core_rd_msr) == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_m
    // R7
    ext_mask_chk: assert property (@(posedge clk) disable iff (rst)
      (core_wr_stb[g] && core_wr_sel[g] == 4'd2 && !ext_bits[g])
        |-> (core_wr_data[g][7:4] == 4'h0));
  end
endmodule

bind uart_regdec uart_regdec_chk #(.NCH(uart_regdec_pkg::NCH), .DW(DW)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .cs_n         (cs_n),
  .core_wr_stb  (core_wr_stb),
  .core_wr_sel  (core_wr_sel),
  .core_wr_data (core_wr_data),
  .core_rd_rhr  (core_rd_rhr),
  .core_rd_msr  (core_rd_msr),
  .cw_bits      (cw_bits),
  .ext_bits     (ext_bits)
);

// File: tb/uart_regdec_tb_top.sv
`timescale 1ns/1ps
module uart_regdec_tb_top;
  localparam logic [7:0] REV = 8'h01;
  localparam logic [7:0] DID = 8'h0A;

  logic clk = 1'b0;
  logic rst;
  logic cs_n, ch_sel, rd_n, wr_n;
  logic [2:0] addr;
  logic [7:0] wdata, rdata;
  logic [1:0][7:0] core_rhr, core_ier, core_isr, core_mcr, core_lsr, core_msr, core_flvl, core_fc;
  logic [1:0][3:0][7:0] core_xchar;
  logic [1:0] core_wr_stb, core_rd_rhr, core_rd_msr;
  logic [1:0][3:0] core_wr_sel;
  logic [1:0][7:0] core_wr_data;

  always #2.5 clk = ~clk;

  uart_regdec dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ch_sel(ch_sel), .addr(addr),
    .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata), .rdata(rdata),
    .core_rhr(core_rhr), .core_ier(core_ier), .core_isr(core_isr),
    .core_mcr(core_mcr), .core_lsr(core_lsr), .core_msr(core_msr),
    .core_flvl(core_flvl), .core_fc(core_fc), .core_xchar(core_xchar),
    .core_wr_stb(core_wr_stb), .core_wr_sel(core_wr_sel),
    .core_wr_data(core_wr_data), .core_rd_rhr(core_rd_rhr),
    .core_rd_msr(core_rd_msr)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m_lcr[2], m_dll[2], m_dlm[2], m_afr[2], m_fctr[2], m_efr[2], m_spr[2];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_enh(input int i); return m_lcr[i] == 8'hBF; endfunction
  function automatic bit is_div(input int i); return m_lcr[i][7] && m_lcr[i] != 8'hBF; endfunction

  function automatic string tag(input int i, input logic [2:0] a);
    if (is_enh(i)) return "R4";
    if (a == 3'd7) return "R6";
    if (is_div(i) && a <= 3'd1) return "R3 R5";
    if (is_div(i) && a == 3'd2) return "R3";
    return "R11 R7";
  endfunction

  function automatic logic [7:0] exp_rd(input int i, input logic [2:0] a);
    bit e = m_efr[i][4];
    bit z = (m_dll[i] == 8'h00) && (m_dlm[i] == 8'h00);
    case (a)
      3'd0: return is_enh(i) ? core_fc[i] : is_div(i) ? (z ? REV : m_dll[i]) : core_rhr[i];
      3'd1: return is_enh(i) ? m_fctr[i] : is_div(i) ? (z ? DID : m_dlm[i]) : (core_ier[i] & (e ? 8'hFF : 8'h0F));
      3'd2: return is_enh(i) ? m_efr[i] : is_div(i) ? m_afr[i] : (core_isr[i] & (e ? 8'hFF : 8'hCF));
      3'd3: return m_lcr[i];
      3'd4: return is_enh(i) ? core_xchar[i][0] : (core_mcr[i] & (e ? 8'hFF : 8'h1F));
      3'd5: return is_enh(i) ? core_xchar[i][1] : core_lsr[i];
      3'd6: return is_enh(i) ? core_xchar[i][2] : core_msr[i];
      default: return is_enh(i) ? core_xchar[i][3] : (m_fctr[i][6] ? core_flvl[i] : m_spr[i]);
    endcase
  endfunction

  task automatic exp_wr(input int i, input logic [2:0] a, input logic [7:0] d,
                        output logic [3:0] sel, output logic [7:0] dat);
    bit e = m_efr[i][4];
    bit en = is_enh(i);
    bit dv = is_div(i);
    sel = 4'd0;
    dat = d;
    case (a)
      3'd0: if (en) sel = 4'd6; else if (dv) m_dll[i] = d; else sel = 4'd1;
      3'd1: if (en) m_fctr[i] = d; else if (dv) m_dlm[i] = d;
            else begin sel = 4'd2; dat = d & (e ? 8'hFF : 8'h0F); end
      3'd2: if (en) m_efr[i] = d; else if (dv) m_afr[i] = d;
            else begin sel = 4'd3; dat = d & (e ? 8'hFF : 8'hCF); end
      3'd3: m_lcr[i] = d;
      3'd4: if (en) sel = 4'd7; else begin sel = 4'd4; dat = d & (e ? 8'hFF : 8'h1F); end
      3'd5: if (en) sel = 4'd8;
      3'd6: if (en) sel = 4'd9;
      default: if (en) sel = 4'd10; else if (m_fctr[i][6]) sel = 4'd5; else m_spr[i] = d;
    endcase
  endtask

  task automatic rand_core();
    for (int c = 0; c < 2; c++) begin
      core_rhr[c] = 8'($urandom); core_ier[c] = 8'($urandom);
      core_isr[c] = 8'($urandom); core_mcr[c] = 8'($urandom);
      core_lsr[c] = 8'($urandom); core_msr[c] = 8'($urandom);
      core_flvl[c] = 8'($urandom); core_fc[c] = 8'($urandom);
      for (int k = 0; k < 4; k++) core_xchar[c][k] = 8'($urandom);
    end
  endtask

  task automatic do_write(input int i, input logic [2:0] a, input logic [7:0] d, input bit act);
    logic [3:0] es[2];
    logic [7:0] ed[2];
    bit both = act && m_afr[i][0];
    string t[2];
    for (int c = 0; c < 2; c++) begin
      t[c] = tag(c, a);
      es[c] = 4'd0; ed[c] = 8'h00;
    end
    for (int c = 0; c < 2; c++)
      if (act && (c == i || both)) exp_wr(c, a, d, es[c], ed[c]);
    @(negedge clk);
    cs_n = !act; ch_sel = (i == 0); addr = a; wdata = d; wr_n = 1'b0;
    @(negedge clk);
    chk(core_wr_stb == 2'b00, "R9 no commit while wr_n low", 32'(core_wr_stb), 0);
    wr_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      bit es_on = (es[c] != 4'd0);
      bit ok = (core_wr_stb[c] == es_on) &&
               (!es_on || (core_wr_sel[c] == es[c] && core_wr_data[c] == ed[c]));
      chk(ok, $sformatf("R9 R1 R2 %s write ch%0d a%0d", t[c], c, a),
          {core_wr_stb[c], 11'd0, core_wr_sel[c], 8'd0, core_wr_data[c]},
          {es_on, 11'd0, es[c], 8'd0, ed[c]});
    end
    cs_n = 1'b1;
    @(negedge clk);
    chk(core_wr_stb == 2'b00, "R9 strobe one cycle", 32'(core_wr_stb), 0);
  endtask

  task automatic do_read(input int i, input logic [2:0] a);
    logic [7:0] ev;
    logic [1:0] erh, ems;
    rand_core();
    ev = exp_rd(i, a);
    erh = 2'b00; ems = 2'b00;
    erh[i] = (a == 3'd0) && !m_lcr[i][7];
    ems[i] = (a == 3'd6) && !is_enh(i);
    @(negedge clk);
    cs_n = 1'b0; ch_sel = (i == 0); addr = a; rd_n = 1'b0;
    @(negedge clk);
    chk(rdata == ev, $sformatf("R10 %s read ch%0d a%0d", tag(i, a), i, a), 32'(rdata), 32'(ev));
    chk(core_rd_rhr == erh && core_rd_msr == ems, "R10 R1 read pulse",
        {core_rd_rhr, core_rd_msr}, {erh, ems});
    rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 150000 && !done; k++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; cs_n = 1'b1; ch_sel = 1'b1; addr = 3'd0; rd_n = 1'b1; wr_n = 1'b1; wdata = 8'h00;
    rand_core();
    for (int c = 0; c < 2; c++) begin
      m_lcr[c] = 8'h00; m_dll[c] = 8'h00; m_dlm[c] = 8'h00; m_afr[c] = 8'h00;
      m_fctr[c] = 8'h00; m_efr[c] = 8'h00; m_spr[c] = 8'hFF;
    end
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(rdata == 8'h00 && core_wr_stb == 2'b00 && core_rd_rhr == 2'b00 && core_rd_msr == 2'b00,
        "R8 reset outputs", {rdata, core_wr_stb, core_rd_rhr, core_rd_msr}, 0);
    do_read(0, 3'd3);
    do_read(1, 3'd7);
    do_read(0, 3'd7);
    // R11 normal bank and R1 channel choice
    do_write(0, 3'd0, 8'h55, 1'b1);
    do_read(1, 3'd0);
    do_read(0, 3'd6);
    do_write(1, 3'd5, 8'h12, 1'b1);
    do_write(1, 3'd2, 8'hFF, 1'b1);
    // R1 chip select high
    do_write(0, 3'd3, 8'h80, 1'b0);
    do_read(0, 3'd3);
    // R5 identification and R3 divisor bank
    do_write(0, 3'd3, 8'h80, 1'b1);
    do_read(0, 3'd0);
    do_read(0, 3'd1);
    do_write(0, 3'd0, 8'h0C, 1'b1);
    do_read(0, 3'd0);
    do_read(0, 3'd1);
    do_read(0, 3'd6);
    do_write(0, 3'd2, 8'h01, 1'b1);
    do_read(0, 3'd2);
    // R2 concurrent writes
    do_write(0, 3'd3, 8'h00, 1'b1);
    do_write(0, 3'd1, 8'hFF, 1'b1);
    // R4 enhanced bank, R7 extension enable
    do_write(0, 3'd3, 8'hBF, 1'b1);
    do_write(0, 3'd2, 8'h10, 1'b1);
    do_write(0, 3'd4, 8'h11, 1'b1);
    do_read(1, 3'd0);
    do_read(1, 3'd5);
    do_write(0, 3'd1, 8'h40, 1'b1);
    do_write(1, 3'd3, 8'h00, 1'b1);
    do_write(0, 3'd7, 8'h3C, 1'b1);
    do_read(1, 3'd4);
    do_read(1, 3'd7);
    do_write(1, 3'd7, 8'hA5, 1'b1);
    // random mix
    for (int n = 0; n < 400; n++) begin
      int i = int'($urandom % 2);
      logic [2:0] a = 3'($urandom);
      logic [7:0] d = 8'($urandom);
      if ($urandom % 2) begin
        if (a == 3'd3) begin
          case ($urandom % 4)
            0: d = 8'h00;
            1: d = 8'h80;
            2: d = 8'hBF;
            default: d = 8'($urandom);
          endcase
        end else if (a <= 3'd1 && ($urandom % 3) == 0) d = 8'h00;
        do_write(i, a, d, ($urandom % 8) != 0);
      end else begin
        do_read(i, a);
      end
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule